// File: doc/BRIEF.md
# Memory Write Pattern Generator

This block is a self-test engine that fills a region of memory with a known pattern. After a start pulse it issues a fixed number of write commands on a valid/ready command port. Each command carries an address and a data word. A checker that reads the region back later can rebuild the same sequence from the same settings.

Two mode bits are captured at start. One makes the data pseudo-random instead of counting. The other makes the address pseudo-random instead of sequential. A random address is folded into the window that begins at the base address, so the same address can be written more than once. A run input pauses issuing without losing the position. Each accepted command gives a one-cycle acknowledge strobe. A saturating cycle counter measures how long generation took. A clear pulse abandons the current pass and returns the block to idle.

Top module: `mem_pattern_gen`

## Requirements
- R1: After reset, and in the cycle after a clear pulse, the outputs are idle: cmd_valid_o, done_o and ack_o are low and ticks_o is zero.
- R2: A start pulse captures base, end, count and both mode bits, and sets the word index to 0. Exactly count commands are then accepted. done_o rises in the cycle after the last acceptance and stays high, with cmd_valid_o low, until the next start or clear.
- R3: With random-address mode off, word i has address (base + i) mod 2^AW.
- R4: With random-data mode off, word i has data equal to i, zero-extended to DW bits.
- R5: With random-data mode on, the data comes from a 32-bit Galois LFSR. Its next state is (s >> 1) XOR (s[0] ? 32'h80200003 : 0). It is reseeded to 1 at start and steps once per accepted command, so word i uses the state after i steps.
- R6: With random-address mode on, a 16-bit Galois LFSR is used. Its next state is (s >> 1) XOR (s[0] ? 16'hB400 : 0), with seed 1 and the same stepping as in R5. The window size is span = (end − base) mod 2^AW. The address is base + (s mod span), or base when span is 0.
- R7: cmd_valid_o is high only while a pass is active and run_i is high. While run_i is low, no command is issued, and the address and data hold.
- R8: ack_o is high for exactly one cycle, the cycle after each accepted command (cmd_valid_o and cmd_ready_i both high at a clock edge). It is low at all other times.
- R9: ticks_o is cleared by start and by clear. It then increments in every cycle of an active pass, stalled or paused cycles included. It stops when done is reached and saturates at all ones instead of wrapping.
- R10: A count of 0 raises done_o in the cycle after start, with no command issued and ticks_o at 0.
- R11: While cmd_valid_o is high and cmd_ready_i is low, cmd_addr_o and cmd_data_o stay stable.
- R12: When clear and start are pulsed together, clear wins and the block returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle pulse that begins a pass |
| clear_i | input | 1 | One-cycle pulse that returns the block to idle |
| run_i | input | 1 | Allows command issue while high |
| base_i | input | AW | First address of the window |
| end_i | input | AW | End of the window; sets the fold span |
| count_i | input | AW | Number of words to write |
| rand_data_i | input | 1 | Selects LFSR data |
| rand_addr_i | input | 1 | Selects folded LFSR address |
| cmd_valid_o | output | 1 | Write command valid |
| cmd_ready_i | input | 1 | Memory side accepts the command |
| cmd_addr_o | output | AW | Write address |
| cmd_data_o | output | DW | Write data |
| done_o | output | 1 | All words written |
| ack_o | output | 1 | One-cycle strobe per accepted command |
| ticks_o | output | TW | Cycles spent in the active pass |

## Verification
A vector table covers six cases. The plain counting pattern separates the address path from the data path. A base near the top of the address range shows whether the address wraps at AW bits. Random data with sequential addresses tests the data LFSR in isolation. A narrow window with random addresses makes repeated addresses likely and checks the fold. A zero span checks the fallback to the base address. A mid-pass pause shows that the position survives a drop of run_i. A sink that refuses every third cycle separates the acknowledge and tick counts from simple cycle counting. Directed tests then cover the zero-length pass, a clear during a stalled command, and clear colliding with start.

// File: rtl/mpg_pkg.sv
package mpg_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } gen_state_e;
endpackage

// File: rtl/mpg_lfsr.sv
module mpg_lfsr #(
  parameter int           W    = 32,
  parameter logic [W-1:0] POLY = W'(1),
  parameter logic [W-1:0] SEED = W'(1)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         reseed_i,
  input  logic         step_i,
  output logic [W-1:0] state_o
);
  logic [W-1:0] s_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       s_q <= SEED;
    else if (reseed_i) s_q <= SEED;
    else if (step_i)   s_q <= (s_q >> 1) ^ (s_q[0] ? POLY : '0);
  end

  assign state_o = s_q;

  // a nonzero seed can never reach the all-zero lockup state
  a_r5_no_lockup: assert property (@(posedge clk_i) disable iff (!rst_ni) s_q != '0);
endmodule

// File: rtl/mpg_addr_fold.sv
module mpg_addr_fold #(
  parameter int AW = 16
) (
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] span_i,
  input  logic [AW-1:0] rnd_i,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0] offset;

  always_comb begin
    offset = (span_i == '0) ? '0 : rnd_i % span_i;
    addr_o = base_i + offset;
    if (span_i != '0) begin
      a_r6_in_window: assert (offset < span_i);
    end
  end
endmodule

// File: rtl/mpg_tick_cnt.sv
module mpg_tick_cnt #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] MAX = '1;
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (clr_i)                 cnt_q <= '0;
    else if (inc_i && cnt_q != MAX) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  a_r9_saturate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == MAX && !clr_i) |=> cnt_q == MAX);
  a_r9_no_skip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/mem_pattern_gen.sv
module mem_pattern_gen
  import mpg_pkg::*;
#(
  parameter int            AW        = 16,
  parameter int            DW        = 32,
  parameter int            TW        = 32,
  parameter logic [DW-1:0] DATA_POLY = DW'(32'h8020_0003),
  parameter logic [AW-1:0] ADDR_POLY = AW'(16'hB400)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          clear_i,
  input  logic          run_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] end_i,
  input  logic [AW-1:0] count_i,
  input  logic          rand_data_i,
  input  logic          rand_addr_i,
  output logic          cmd_valid_o,
  input  logic          cmd_ready_i,
  output logic [AW-1:0] cmd_addr_o,
  output logic [DW-1:0] cmd_data_o,
  output logic          done_o,
  output logic          ack_o,
  output logic [TW-1:0] ticks_o
);
  gen_state_e    state_q;
  logic [AW-1:0] base_q, span_q, count_q, idx_q;
  logic          rd_q, ra_q, ack_q;
  logic          hs, last, reseed, step;
  logic [DW-1:0] dlfsr;
  logic [AW-1:0] alfsr, rnd_addr;

  assign hs     = cmd_valid_o & cmd_ready_i;
  assign last   = (idx_q == count_q - 1'b1);
  assign reseed = clear_i | start_i;
  assign step   = hs & ~reseed;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      base_q  <= '0;
      span_q  <= '0;
      count_q <= '0;
      idx_q   <= '0;
      rd_q    <= 1'b0;
      ra_q    <= 1'b0;
    end else if (clear_i) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
    end else if (start_i) begin
      base_q  <= base_i;
      span_q  <= end_i - base_i;
      count_q <= count_i;
      rd_q    <= rand_data_i;
      ra_q    <= rand_addr_i;
      idx_q   <= '0;
      state_q <= (count_i == '0) ? ST_DONE : ST_RUN;
    end else if (hs) begin
      idx_q <= idx_q + 1'b1;
      if (last) state_q <= ST_DONE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ack_q <= 1'b0;
    else         ack_q <= hs & ~clear_i;
  end

  mpg_lfsr #(.W(DW), .POLY(DATA_POLY), .SEED(DW'(1))) u_data_lfsr (
    .clk_i(clk_i), .rst_ni(rst_ni), .reseed_i(reseed), .step_i(step), .state_o(dlfsr)
  );

  mpg_lfsr #(.W(AW), .POLY(ADDR_POLY), .SEED(AW'(1))) u_addr_lfsr (
    .clk_i(clk_i), .rst_ni(rst_ni), .reseed_i(reseed), .step_i(step), .state_o(alfsr)
  );

  mpg_addr_fold #(.AW(AW)) u_fold (
    .base_i(base_q), .span_i(span_q), .rnd_i(alfsr), .addr_o(rnd_addr)
  );

  mpg_tick_cnt #(.W(TW)) u_ticks (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(reseed),
    .inc_i(state_q == ST_RUN), .cnt_o(ticks_o)
  );

  assign cmd_valid_o = (state_q == ST_RUN) & run_i;
  assign cmd_addr_o  = ra_q ? rnd_addr : base_q + idx_q;
  assign cmd_data_o  = rd_q ? dlfsr : DW'(idx_q);
  assign done_o      = (state_q == ST_DONE);
  assign ack_o       = ack_q;

  a_r8_ack_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && cmd_ready_i && !clear_i) |=> ack_o);
  a_r8_ack_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> $past(cmd_valid_o && cmd_ready_i));
  a_r11_stall_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && !cmd_ready_i && !start_i && !clear_i)
      |=> ($stable(cmd_addr_o) && $stable(cmd_data_o)));
  a_r7_pause_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !start_i && !clear_i)
      |=> ($stable(cmd_addr_o) && $stable(cmd_data_o) && !ack_o));
  a_r2_done_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i && !clear_i) |=> (done_o && !cmd_valid_o));
  a_r10_zero_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !clear_i && count_i == '0) |=> (done_o && !cmd_valid_o));
  a_r12_clear_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (!done_o && !cmd_valid_o && ticks_o == '0));
endmodule

// File: tb/mem_pattern_gen_test.sv
`timescale 1ns/1ps
module mem_pattern_gen_test;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int TW = 32;

  typedef struct packed {
    logic [15:0] base;
    logic [15:0] endp;
    logic [15:0] cnt;
    logic        rd;
    logic        ra;
    logic [1:0]  rdy_mode;
    logic [7:0]  pause_at;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{16'h0010, 16'h0100, 16'd8,  1'b0, 1'b0, 2'd0, 8'hFF},
    '{16'hFFFC, 16'h0000, 16'd6,  1'b0, 1'b0, 2'd1, 8'hFF},
    '{16'h0200, 16'h0300, 16'd10, 1'b1, 1'b0, 2'd0, 8'hFF},
    '{16'h0100, 16'h0107, 16'd12, 1'b0, 1'b1, 2'd1, 8'hFF},
    '{16'h0040, 16'h0040, 16'd5,  1'b1, 1'b1, 2'd0, 8'hFF},
    '{16'h1000, 16'h2000, 16'd9,  1'b0, 1'b0, 2'd0, 8'd3}
  };

  logic clk = 1'b0, rst_ni = 1'b0;
  logic start_i = 1'b0, clear_i = 1'b0, run_i = 1'b0;
  logic rand_data_i = 1'b0, rand_addr_i = 1'b0, cmd_ready_i = 1'b0;
  logic [AW-1:0] base_i = '0, end_i = '0, count_i = '0;
  logic cmd_valid_o, done_o, ack_o;
  logic [AW-1:0] cmd_addr_o;
  logic [DW-1:0] cmd_data_o;
  logic [TW-1:0] ticks_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  mem_pattern_gen #(.AW(AW), .DW(DW), .TW(TW)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .clear_i(clear_i), .run_i(run_i),
    .base_i(base_i), .end_i(end_i), .count_i(count_i),
    .rand_data_i(rand_data_i), .rand_addr_i(rand_addr_i),
    .cmd_valid_o(cmd_valid_o), .cmd_ready_i(cmd_ready_i),
    .cmd_addr_o(cmd_addr_o), .cmd_data_o(cmd_data_o),
    .done_o(done_o), .ack_o(ack_o), .ticks_o(ticks_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] nxt32(input logic [31:0] s);
    return (s >> 1) ^ (s[0] ? 32'h8020_0003 : 32'h0);
  endfunction

  function automatic logic [15:0] nxt16(input logic [15:0] s);
    return (s >> 1) ^ (s[0] ? 16'hB400 : 16'h0);
  endfunction

  task automatic run_vec(input vec_t v);
    logic [31:0] ds = 32'h1;
    logic [15:0] as = 16'h1;
    logic [15:0] span = v.endp - v.base;
    logic [15:0] exp_a;
    logic [31:0] exp_d;
    logic [TW-1:0] t_end;
    int idx = 0, acks = 0, run_cycles = 0, pause_left = 4;
    bit prev_hs = 1'b0, hs, seen_done = 1'b0;
    @(negedge clk);
    base_i = v.base; end_i = v.endp; count_i = v.cnt;
    rand_data_i = v.rd; rand_addr_i = v.ra;
    run_i = 1'b1; cmd_ready_i = 1'b0; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int i = 0; i < 2000; i++) begin
      chk(ack_o == prev_hs, "R8", "ack strobe", ack_o, prev_hs);
      if (ack_o) acks++;
      if (done_o) begin seen_done = 1'b1; break; end
      run_cycles++;
      if (idx == int'(v.pause_at) && pause_left > 0) begin
        run_i = 1'b0; pause_left--;
      end else run_i = 1'b1;
      cmd_ready_i = (v.rdy_mode == 2'd0) ? 1'b1 : (i % 3 != 2);
      #1;
      if (!run_i) chk(!cmd_valid_o, "R7", "valid while paused", cmd_valid_o, 0);
      hs = cmd_valid_o && cmd_ready_i;
      if (hs) begin
        if (v.ra) exp_a = (span == 16'h0) ? v.base : v.base + (as % span);
        else      exp_a = v.base + 16'(idx);
        exp_d = v.rd ? ds : 32'(idx);
        chk(cmd_addr_o == exp_a, v.ra ? "R6" : "R3", "address", cmd_addr_o, exp_a);
        chk(cmd_data_o == exp_d, v.rd ? "R5" : "R4", "data", cmd_data_o, exp_d);
        idx++;
        ds = nxt32(ds);
        as = nxt16(as);
      end
      prev_hs = hs;
      @(negedge clk);
    end
    chk(seen_done, "R2", "done reached", seen_done, 1);
    chk(idx == int'(v.cnt), "R2", "command count", idx, v.cnt);
    chk(acks == int'(v.cnt), "R8", "ack count", acks, v.cnt);
    chk(ticks_o == TW'(run_cycles), "R9", "ticks", ticks_o, run_cycles);
    t_end = ticks_o;
    run_i = 1'b1; cmd_ready_i = 1'b1;
    @(negedge clk);
    chk(!ack_o, "R8", "ack after done", ack_o, 0);
    chk(done_o && !cmd_valid_o, "R2", "done held", {done_o, cmd_valid_o}, 2'b10);
    chk(ticks_o == t_end, "R9", "ticks stop at done", ticks_o, t_end);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL R2 watchdog expired: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [AW-1:0] a0;
    logic [DW-1:0] d0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(!cmd_valid_o && !done_o && !ack_o, "R1", "idle outputs after reset",
        {cmd_valid_o, done_o, ack_o}, 0);
    chk(ticks_o == '0, "R1", "ticks after reset", ticks_o, 0);

    for (int k = 0; k < 6; k++) run_vec(VECS[k]);

    // R10: zero-length pass
    @(negedge clk);
    count_i = '0; base_i = 16'h0500; end_i = 16'h0600; run_i = 1'b1; cmd_ready_i = 1'b1;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(done_o, "R10", "done after zero-length start", done_o, 1);
    chk(!cmd_valid_o, "R10", "no command for zero length", cmd_valid_o, 0);
    chk(ticks_o == '0, "R10", "ticks for zero length", ticks_o, 0);
    @(negedge clk);
    chk(!ack_o && !cmd_valid_o, "R10", "still no command", {ack_o, cmd_valid_o}, 0);

    // R11 and R1: stall, then clear during the stalled command
    count_i = 16'd20; base_i = 16'h0A00; end_i = 16'h0B00;
    rand_data_i = 1'b0; rand_addr_i = 1'b0; cmd_ready_i = 1'b0; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    a0 = cmd_addr_o; d0 = cmd_data_o;
    chk(cmd_valid_o && a0 == 16'h0A00, "R11", "first stalled command", a0, 16'h0A00);
    repeat (3) @(negedge clk);
    chk(cmd_addr_o == a0 && cmd_data_o == d0, "R11", "address held while stalled",
        cmd_addr_o, a0);
    chk(ticks_o == TW'(3), "R9", "ticks count stalled cycles", ticks_o, 3);
    clear_i = 1'b1;
    @(negedge clk);
    clear_i = 1'b0;
    chk(!cmd_valid_o && !done_o && !ack_o, "R1", "idle after clear",
        {cmd_valid_o, done_o, ack_o}, 0);
    chk(ticks_o == '0, "R1", "ticks cleared", ticks_o, 0);

    // R12: clear and start together
    cmd_ready_i = 1'b1; clear_i = 1'b1; start_i = 1'b1;
    @(negedge clk);
    clear_i = 1'b0; start_i = 1'b0;
    chk(!cmd_valid_o && !done_o, "R12", "clear beats start", {cmd_valid_o, done_o}, 0);
    @(negedge clk);
    chk(!cmd_valid_o && !ack_o, "R12", "stays idle", {cmd_valid_o, ack_o}, 0);

    // R2: restart from idle begins at index 0
    run_vec(VECS[0]);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule